// File: doc/BRIEF.md
# Calibration Request Handshake Sequencer

This block sequences calibration of a converter core. Once reset is released it starts a calibration on its own, and it starts another one each time software raises a one-bit calibrate request in its control register. Each start is a one-cycle pulse to an external calibration engine. The block then waits for the engine's done strobe. A busy status bit is high from the start of a calibration until the strobe arrives, so software can poll it.

The software protocol is level-based. Software sets the request bit, waits for the busy bit to drop, and then clears the request bit. Leaving the request high after completion parks the sequencer until it is cleared, so a fresh 0-to-1 transition is needed for each new calibration. While the clock-valid input is low, all sequencing is frozen. The current state code is exposed on a debug output.

Top module: `calseq_ctrl`

## Requirements
- R1: While reset is held and directly after it, the debug state is IDLE (code 0), busy is 1, the start pulse is 0 and the request readback is 0.
- R2: At the first clock edge after reset with clock-valid high, the state moves from IDLE to CAL_RUN (code 1) and a start pulse is issued without any software request.
- R3: A write of 1 to the request bit while in NORMAL (code 3) moves the state to CAL_RUN at that same edge, with busy 1 and a start pulse in the following cycle.
- R4: The start output is high for exactly one cycle, and only in the first cycle of each CAL_RUN residency.
- R5: Busy stays 1 for the whole CAL_RUN residency and drops at the edge where done is sampled high, so it reads 1 for exactly L cycles when done follows the start pulse by L cycles.
- R6: If the request bit is 1 when done is accepted, the state becomes WAIT_CLEAR (code 2) with busy 0 and no new start. Writing the request bit to 0 moves it to NORMAL at that edge.
- R7: If the request bit is 0 when done is accepted, the state goes straight to NORMAL with busy 0.
- R8: A request written during the automatic post-reset calibration merges into that run. Exactly one start pulse is seen, and the sequence ends in WAIT_CLEAR.
- R9: While clock-valid is low, the state is held, no start is issued and done strobes are ignored. Request writes still update the readback, and a request left at 1 takes effect once clock-valid returns.
- R10: A done strobe outside CAL_RUN changes neither the state nor busy.
- R11: The request readback always shows the value most recently written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ok_i | input | 1 | Clock-valid; low freezes sequencing |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_cal_i | input | 1 | Value written to the calibrate request bit |
| cal_rd_o | output | 1 | Readback of the calibrate request bit |
| busy_o | output | 1 | Calibration-in-progress status bit |
| eng_start_o | output | 1 | One-cycle start pulse to the calibration engine |
| eng_done_i | input | 1 | Done strobe from the calibration engine |
| state_dbg_o | output | 2 | Current state code (0 IDLE, 1 CAL_RUN, 2 WAIT_CLEAR, 3 NORMAL) |

## Verification
The bench builds two copies of the block from the same stimulus: one with the busy bit registered from the next state (the default) and one with it decoded from the current state. Both must give identical cycle-exact results. Engine latency is swept from 1 to 6 cycles, each with the request cleared before and after completion, so the busy-length rule and both exits from CAL_RUN are covered. Directed sequences cover the merged post-reset request, freezes during reset, run and NORMAL, and stray done strobes.

// File: rtl/calseq_pkg.sv
package calseq_pkg;
   localparam int ST_W = 2;

   typedef enum logic [ST_W-1:0] {
      ST_IDLE       = 2'd0,
      ST_CAL_RUN    = 2'd1,
      ST_WAIT_CLEAR = 2'd2,
      ST_NORMAL     = 2'd3
   } cal_state_e;

   function automatic logic state_busy(cal_state_e s);
      return (s == ST_IDLE) || (s == ST_CAL_RUN);
   endfunction
endpackage

// File: rtl/calseq_reqbit.sv
module calseq_reqbit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic val_i,
   output logic lvl_next_o,
   output logic lvl_q_o
);
   logic req_q;

   assign lvl_next_o = wr_i ? val_i : req_q;
   assign lvl_q_o    = req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= lvl_next_o;
   end

   assert_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (req_q == $past(val_i)));
endmodule

// File: rtl/calseq_fsm.sv
module calseq_fsm
   import calseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clk_ok_i,
   input  logic       req_lvl_i,
   input  logic       done_i,
   output cal_state_e state_q_o,
   output cal_state_e state_d_o,
   output logic       start_o
);
   cal_state_e st_q, st_d;
   logic       start_q;

   always_comb begin
      st_d = st_q;
      if (clk_ok_i) begin
         unique case (st_q)
            ST_IDLE:       st_d = ST_CAL_RUN;
            ST_CAL_RUN:    if (done_i) st_d = req_lvl_i ? ST_WAIT_CLEAR : ST_NORMAL;
            ST_WAIT_CLEAR: if (!req_lvl_i) st_d = ST_NORMAL;
            ST_NORMAL:     if (req_lvl_i) st_d = ST_CAL_RUN;
            default:       st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         start_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         start_q <= (st_d == ST_CAL_RUN) && (st_q != ST_CAL_RUN);
      end
   end

   assign state_q_o = st_q;
   assign state_d_o = st_d;
   assign start_o   = start_q;

   assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_ok_i |=> (st_q == $past(st_q)) && !start_q);
   assert_idle_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> (st_q != ST_IDLE));
   assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);
endmodule

// File: rtl/calseq_status.sv
module calseq_status
   import calseq_pkg::*;
#(
   parameter bit FROM_NEXT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  cal_state_e state_q_i,
   input  cal_state_e state_d_i,
   output logic       busy_o
);
   generate
      if (FROM_NEXT) begin : g_reg
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b1;
            else        busy_q <= state_busy(state_d_i);
         end
         assign busy_o = busy_q;
      end else begin : g_dec
         assign busy_o = state_busy(state_q_i);
      end
   endgenerate

   assert_busy_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q_i == ST_CAL_RUN) |-> busy_o);
endmodule

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
   import calseq_pkg::*;
#(
   parameter bit BUSY_FROM_NEXT = 1'b1,
   parameter int DBG_W          = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_ok_i,
   input  logic             reg_wr_i,
   input  logic             reg_cal_i,
   output logic             cal_rd_o,
   output logic             busy_o,
   output logic             eng_start_o,
   input  logic             eng_done_i,
   output logic [DBG_W-1:0] state_dbg_o
);
   initial begin
      assert (DBG_W == ST_W) else $error("DBG_W must equal the state width");
   end

   logic       req_next, req_q;
   cal_state_e st_q, st_d;

   calseq_reqbit u_req (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .val_i(reg_cal_i),
      .lvl_next_o(req_next), .lvl_q_o(req_q)
   );

   calseq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .clk_ok_i(clk_ok_i), .req_lvl_i(req_next),
      .done_i(eng_done_i), .state_q_o(st_q), .state_d_o(st_d), .start_o(eng_start_o)
   );

   calseq_status #(.FROM_NEXT(BUSY_FROM_NEXT)) u_stat (
      .clk(clk), .rst_n(rst_n), .state_q_i(st_q), .state_d_i(st_d), .busy_o(busy_o)
   );

   assign cal_rd_o    = req_q;
   assign state_dbg_o = DBG_W'(st_q);

   assert_start_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start_o |-> (st_q == ST_CAL_RUN) && ($past(st_q) != ST_CAL_RUN));
   assert_clear_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT_CLEAR) |-> !eng_start_o && !busy_o);
   assert_normal_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_NORMAL && clk_ok_i && reg_wr_i && reg_cal_i) |=> eng_start_o && busy_o);
   assert_stray_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_NORMAL && !req_next) |=> (st_q == ST_NORMAL) && !busy_o);
endmodule

// File: tb/calseq_ctrl_tb_top.sv
module calseq_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_ok = 1'b1;
   logic wr = 1'b0;
   logic wval = 1'b0;
   logic done = 1'b0;
   logic rd_a, busy_a, start_a, rd_b, busy_b, start_b;
   logic [1:0] dbg_a, dbg_b;
   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   calseq_ctrl #(.BUSY_FROM_NEXT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .clk_ok_i(clk_ok), .reg_wr_i(wr), .reg_cal_i(wval),
      .cal_rd_o(rd_a), .busy_o(busy_a), .eng_start_o(start_a), .eng_done_i(done),
      .state_dbg_o(dbg_a));

   calseq_ctrl #(.BUSY_FROM_NEXT(1'b0)) dut_b (
      .clk(clk), .rst_n(rst_n), .clk_ok_i(clk_ok), .reg_wr_i(wr), .reg_cal_i(wval),
      .cal_rd_o(rd_b), .busy_o(busy_b), .eng_start_o(start_b), .eng_done_i(done),
      .state_dbg_o(dbg_b));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_all(string req, int st, bit bsy, bit st_pulse, bit rd);
      int act_a, act_b, exp_v;
      exp_v = {st[1:0], bsy, st_pulse, rd};
      act_a = {dbg_a, busy_a, start_a, rd_a};
      act_b = {dbg_b, busy_b, start_b, rd_b};
      checks++;
      if (act_a != exp_v || act_b != exp_v) begin
         errors++;
         $display("FAIL %s: actual {st,busy,start,rd} a=%h b=%h expected %h", req, act_a, act_b, exp_v);
      end
   endtask

   task automatic write_req(bit v);
      wr = 1'b1; wval = v;
      tick();
      wr = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(); tick();
      expect_all("R1 in reset", 0, 1, 0, 0);
      rst_n = 1'b1;
      expect_all("R1 after release", 0, 1, 0, 0);
   endtask

   // from first CAL_RUN cycle (start already checked): L cycles busy, then done
   task automatic finish_run(string req, int lat, bit rq, int exp_st);
      for (int i = 1; i < lat; i++) begin
         tick();
         expect_all("R5 busy held", 1, 1, 0, rq);
      end
      done = 1'b1;
      tick();
      done = 1'b0;
      expect_all(req, exp_st, 0, 0, rq);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 50000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      #1;
      // post-reset calibration
      do_reset();
      tick();
      expect_all("R2 auto start", 1, 1, 1, 0);
      finish_run("R7 auto done", 3, 0, 3);

      // sweep latency and clear ordering
      for (int lat = 1; lat <= 6; lat++) begin
         for (int ord = 0; ord < 2; ord++) begin
            write_req(1'b1);
            expect_all("R3 request start", 1, 1, 1, 1);
            if (ord == 0) begin
               finish_run("R6 park in wait-clear", lat, 1, 2);
               for (int k = 0; k < 3; k++) begin
                  tick();
                  expect_all("R6 no restart while held", 2, 0, 0, 1);
               end
               write_req(1'b0);
               expect_all("R6 clear to normal", 3, 0, 0, 0);
            end else begin
               if (lat > 1) begin
                  write_req(1'b0);
                  expect_all("R11 early clear readback", 1, 1, 0, 0);
                  finish_run("R7 direct to normal", lat - 1, 0, 3);
               end else begin
                  finish_run("R6 park lat1", 1, 1, 2);
                  write_req(1'b0);
                  expect_all("R6 clear", 3, 0, 0, 0);
               end
            end
         end
      end

      // stray done in NORMAL
      done = 1'b1; tick(); done = 1'b0;
      expect_all("R10 stray done", 3, 0, 0, 0);

      // merged request during post-reset run
      do_reset();
      tick();
      expect_all("R2 auto start again", 1, 1, 1, 0);
      write_req(1'b1);
      expect_all("R8 merged, no second start", 1, 1, 0, 1);
      finish_run("R8 ends in wait-clear", 2, 1, 2);
      done = 1'b1; tick(); done = 1'b0;
      expect_all("R10 done in wait-clear", 2, 0, 0, 1);
      write_req(1'b0);
      expect_all("R8 clear", 3, 0, 0, 0);

      // freeze during reset
      clk_ok = 1'b0;
      do_reset();
      tick(); tick();
      expect_all("R9 frozen idle", 0, 1, 0, 0);
      clk_ok = 1'b1;
      tick();
      expect_all("R9 resume start", 1, 1, 1, 0);
      clk_ok = 1'b0;
      done = 1'b1; tick(); done = 1'b0;
      expect_all("R9 done ignored when frozen", 1, 1, 0, 0);
      clk_ok = 1'b1;
      finish_run("R9 done after resume", 1, 0, 3);

      // freeze in NORMAL with request written
      clk_ok = 1'b0;
      write_req(1'b1);
      expect_all("R9 write accepted while frozen", 3, 0, 0, 1);
      tick();
      expect_all("R9 no start while frozen", 3, 0, 0, 1);
      clk_ok = 1'b1;
      tick();
      expect_all("R9 level request taken on resume", 1, 1, 1, 1);
      finish_run("R6 after resume", 2, 1, 2);
      write_req(1'b0);
      expect_all("R6 final clear", 3, 0, 0, 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule